// File: doc/BRIEF.md
# Ethernet Transmit Deferral Timer

This block decides when a MAC transmitter may start its next frame. It measures the quiet time on the medium in nibble times, one count per tick of a nibble-rate strobe. The count restarts at the end of every transmitted frame. Once the count reaches the required gap and the transmitter is asking to send, the block raises a one-cycle permit strobe. The block handles timing only: collision handling, backoff and framing belong to other blocks.

Each gap field holds the desired gap less a fixed offset. The offset is 3 nibble times in full duplex and 6 in half duplex. When the transmitter is sending frames back to back, one programmed gap applies. Otherwise, in half duplex, the gap is split in two. If carrier sense appears in the early part, the block defers and starts timing again once carrier goes away. If carrier appears in the late part, the block ignores it and keeps counting, so that access to the medium stays fair. In full duplex, carrier sense plays no part at all.

Top module: `eth_tx_defer`

## Requirements
- R1: While reset is low and right after it is released, `tx_permit` is 0. The gap count starts from zero at reset release.
- R2: With `full_duplex`=1, the permit comes on the tick that brings the count to `gap_b2b`+3. This holds whatever the value of `back_to_back`.
- R3: With `full_duplex`=0 and `back_to_back`=1, the permit comes on the tick that brings the count to `gap_b2b`+6.
- R4: With `full_duplex`=0 and `back_to_back`=0, the permit comes on the tick that brings the count to `gap_win2`+6.
- R5: The count advances only in cycles where `nib_tick`=1. Any number of cycles without a tick gives no permit.
- R6: In half duplex without back-to-back, carrier seen while the count is below `gap_win1` makes the block defer. The count is held at zero for as long as carrier stays up. After carrier drops, a full `gap_win2`+6 ticks are needed.
- R7: In half duplex without back-to-back, carrier that first appears once the count is at or above `gap_win1` is ignored. The permit comes on the same tick as it would with no carrier.
- R8: In full duplex, carrier sense is ignored, including carrier that is held high for the whole gap.
- R9: `tx_permit` is a single-cycle pulse, given at most once per gap. It is allowed again only after a `tx_done` pulse.
- R10: `tx_permit` is 0 while `tx_req`=0. If the request arrives after the gap has expired, the permit is given in that same cycle.
- R11: A `tx_done` pulse sets the count back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_tick | input | 1 | One-cycle strobe, one per nibble time |
| carrier | input | 1 | Carrier sense from the PHY |
| tx_req | input | 1 | Transmitter has a frame pending |
| tx_done | input | 1 | One-cycle pulse at end of a transmitted frame |
| back_to_back | input | 1 | Next frame follows directly on the previous one |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| gap_b2b | input | 7 | Back-to-back gap, desired nibble times less offset |
| gap_win1 | input | 7 | Early (deferring) part of split gap, raw nibble count, at most gap_win2 |
| gap_win2 | input | 7 | Split gap length, desired nibble times less offset |
| tx_permit | output | 1 | One-cycle strobe: transmission may start |

## Verification
A table of mode and gap settings is run through the block: full duplex with and without the back-to-back flag, half-duplex back-to-back, and half-duplex split gaps at small, recommended, large and extreme values. The tick count to the permit tells the two offsets and the two gap fields apart. Carrier is raised once below the early limit and once above it, which tells a restart from a carrier that is ignored. A further run repeats this with carrier held high in full duplex. Separate runs delay the request, stop the ticks and repeat a gap without a frame end in between, to check the pulse, tick gating and re-arming behaviour.

// File: rtl/eth_defer_pkg.sv
package eth_defer_pkg;
   // widen a gap field and add the mode offset
   function automatic logic [7:0] add_offset(input logic [6:0] field, input int unsigned off);
      return {1'b0, field} + 8'(off);
   endfunction
endpackage

// File: rtl/eth_defer_target.sv
module eth_defer_target #(
   parameter int unsigned GAP_W      = 7,
   parameter int unsigned FD_OFFSET  = 3,
   parameter int unsigned HD_OFFSET  = 6,
   parameter bit          HD_SUPPORT = 1'b1,
   localparam int unsigned CNT_W     = GAP_W + 1
) (
   input  logic             full_duplex,
   input  logic             back_to_back,
   input  logic [GAP_W-1:0] gap_b2b,
   input  logic [GAP_W-1:0] gap_win1,
   input  logic [GAP_W-1:0] gap_win2,
   output logic [CNT_W-1:0] target,
   output logic [CNT_W-1:0] win1_lim,
   output logic             split_mode
);
   logic fd_eff;

   generate
      if (HD_SUPPORT) begin : g_hd
         assign fd_eff = full_duplex;
      end else begin : g_fd_only
         assign fd_eff = 1'b1;
      end
   endgenerate

   assign split_mode = !fd_eff && !back_to_back;
   assign win1_lim   = {1'b0, gap_win1};

   always_comb begin
      if (fd_eff)
         target = {1'b0, gap_b2b} + CNT_W'(FD_OFFSET);
      else if (back_to_back)
         target = {1'b0, gap_b2b} + CNT_W'(HD_OFFSET);
      else
         target = {1'b0, gap_win2} + CNT_W'(HD_OFFSET);
   end
endmodule

// File: rtl/eth_defer_timer.sv
module eth_defer_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nib_tick,
   input  logic             carrier,
   input  logic             tx_done,
   input  logic             split_mode,
   input  logic [CNT_W-1:0] win1_lim,
   output logic [CNT_W-1:0] cnt_q,
   output logic             defer_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         defer_q <= 1'b0;
      end else if (tx_done) begin
         cnt_q   <= '0;
         defer_q <= 1'b0;
      end else if (defer_q) begin
         cnt_q <= '0;
         if (!carrier || !split_mode) defer_q <= 1'b0;
      end else if (split_mode && carrier && (cnt_q < win1_lim)) begin
         cnt_q   <= '0;
         defer_q <= 1'b1;
      end else if (nib_tick && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/eth_defer_permit.sv
module eth_defer_permit #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_req,
   input  logic             tx_done,
   input  logic             defer_q,
   input  logic [CNT_W-1:0] cnt_q,
   input  logic [CNT_W-1:0] target,
   output logic             tx_permit
);
   logic armed_q;

   assign tx_permit = armed_q && tx_req && !defer_q && (cnt_q >= target);

   always_ff @(posedge clk) begin
      if (!rst_n)          armed_q <= 1'b1;
      else if (tx_done)    armed_q <= 1'b1;
      else if (tx_permit)  armed_q <= 1'b0;
   end
endmodule

// File: rtl/eth_tx_defer.sv
module eth_tx_defer #(
   parameter int unsigned GAP_W      = 7,
   parameter int unsigned FD_OFFSET  = 3,
   parameter int unsigned HD_OFFSET  = 6,
   parameter bit          HD_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nib_tick,
   input  logic             carrier,
   input  logic             tx_req,
   input  logic             tx_done,
   input  logic             back_to_back,
   input  logic             full_duplex,
   input  logic [GAP_W-1:0] gap_b2b,
   input  logic [GAP_W-1:0] gap_win1,
   input  logic [GAP_W-1:0] gap_win2,
   output logic             tx_permit
);
   localparam int unsigned CNT_W = GAP_W + 1;

   generate
      if (GAP_W < 2) begin : g_bad_w
         $error("GAP_W must be at least 2");
      end
      if (FD_OFFSET >= (1 << GAP_W) || HD_OFFSET >= (1 << GAP_W)) begin : g_bad_off
         $error("gap offsets must fit in a gap field");
      end
   endgenerate

   logic [CNT_W-1:0] target, win1_lim, cnt_q;
   logic             split_mode, defer_q;

   eth_defer_target #(
      .GAP_W(GAP_W), .FD_OFFSET(FD_OFFSET), .HD_OFFSET(HD_OFFSET), .HD_SUPPORT(HD_SUPPORT)
   ) target_i (
      .full_duplex(full_duplex), .back_to_back(back_to_back),
      .gap_b2b(gap_b2b), .gap_win1(gap_win1), .gap_win2(gap_win2),
      .target(target), .win1_lim(win1_lim), .split_mode(split_mode)
   );

   eth_defer_timer #(.CNT_W(CNT_W)) timer_i (
      .clk(clk), .rst_n(rst_n), .nib_tick(nib_tick), .carrier(carrier),
      .tx_done(tx_done), .split_mode(split_mode), .win1_lim(win1_lim),
      .cnt_q(cnt_q), .defer_q(defer_q)
   );

   eth_defer_permit #(.CNT_W(CNT_W)) permit_i (
      .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_done(tx_done),
      .defer_q(defer_q), .cnt_q(cnt_q), .target(target), .tx_permit(tx_permit)
   );
endmodule

// File: rtl/eth_tx_defer_chk.sv
module eth_tx_defer_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             nib_tick,
   input logic             tx_req,
   input logic             tx_done,
   input logic             full_duplex,
   input logic             tx_permit,
   input logic             defer_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] win1_lim
);
   // R9
   permit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_permit |=> !tx_permit);
   // R10
   permit_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_permit |-> tx_req);
   // R5
   tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nib_tick |=> (cnt_q == $past(cnt_q) || cnt_q == '0));
   // R11
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> (cnt_q == '0));
   // R8
   fd_no_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_duplex |=> !defer_q);
   // R7
   late_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!defer_q && cnt_q >= win1_lim && !tx_done) |=> !defer_q);
endmodule

bind eth_tx_defer eth_tx_defer_chk #(.CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .nib_tick(nib_tick), .tx_req(tx_req),
   .tx_done(tx_done), .full_duplex(full_duplex), .tx_permit(tx_permit),
   .defer_q(defer_q), .cnt_q(cnt_q), .win1_lim(win1_lim)
);

// File: tb/eth_tx_defer_tb_top.sv
module eth_tx_defer_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic nib_tick = 1'b0, carrier = 1'b0, tx_req = 1'b0, tx_done = 1'b0;
   logic back_to_back = 1'b0, full_duplex = 1'b1;
   logic [6:0] gap_b2b = '0, gap_win1 = '0, gap_win2 = 7'h12;
   logic tx_permit;
   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   eth_tx_defer dut_i (
      .clk(clk), .rst_n(rst_n), .nib_tick(nib_tick), .carrier(carrier),
      .tx_req(tx_req), .tx_done(tx_done), .back_to_back(back_to_back),
      .full_duplex(full_duplex), .gap_b2b(gap_b2b), .gap_win1(gap_win1),
      .gap_win2(gap_win2), .tx_permit(tx_permit)
   );

   // {fd, b2b, gap_b2b, gap_win1, gap_win2, expected ticks}
   localparam logic [30:0] VEC [8] = '{
      {1'b1, 1'b1, 7'h15, 7'h00, 7'h12, 8'd24},
      {1'b1, 1'b0, 7'h15, 7'h00, 7'h12, 8'd24},
      {1'b0, 1'b1, 7'h12, 7'h00, 7'h30, 8'd24},
      {1'b0, 1'b0, 7'h40, 7'h0C, 7'h12, 8'd24},
      {1'b0, 1'b0, 7'h00, 7'h10, 7'h30, 8'd54},
      {1'b1, 1'b1, 7'h00, 7'h00, 7'h00, 8'd3},
      {1'b0, 1'b1, 7'h7F, 7'h00, 7'h00, 8'd133},
      {1'b0, 1'b0, 7'h7F, 7'h00, 7'h00, 8'd6}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_time();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic frame_end();
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
   endtask

   // one tick; permit sampled after the edge that counted it
   task automatic tick_once(output logic p);
      nib_tick = 1'b1;
      @(negedge clk);
      nib_tick = 1'b0;
      p = tx_permit;
      @(negedge clk);
   endtask

   task automatic ticks(input int n, output int seen);
      logic p;
      seen = 0;
      for (int i = 0; i < n; i++) begin
         tick_once(p);
         if (p) seen++;
      end
   endtask

   task automatic measure(output int n);
      logic p;
      n = 0;
      for (int i = 0; i < 300; i++) begin
         tick_once(p);
         n++;
         if (p) break;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_time();
   end

   initial begin
      int n, seen;
      tx_req = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset holds permit low
      check("R1 permit in reset", int'(tx_permit), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 permit after reset", int'(tx_permit), 0);
      measure(n);
      check("R1 count from reset (fd, 0+3)", n, 3);

      // table walk: R2 R3 R4
      foreach (VEC[k]) begin
         {full_duplex, back_to_back, gap_b2b, gap_win1, gap_win2} = VEC[k][30:8];
         frame_end();
         measure(n);
         check($sformatf("R2/R3/R4 vector %0d", k), n, int'(VEC[k][7:0]));
      end

      // R5: no ticks, no permit
      full_duplex = 1'b1; gap_b2b = 7'h02;
      frame_end();
      seen = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (tx_permit) seen++;
      end
      check("R5 no permit without ticks", seen, 0);
      measure(n);
      check("R5 ticks after idle", n, 5);

      // R9: single pulse, once per gap
      @(negedge clk);
      check("R9 pulse one cycle", int'(tx_permit), 0);
      ticks(20, seen);
      check("R9 no second permit", seen, 0);
      frame_end();
      measure(n);
      check("R9 rearmed after frame end", n, 5);

      // R10: no request, then late request
      tx_req = 1'b0;
      frame_end();
      ticks(10, seen);
      check("R10 no permit without request", seen, 0);
      tx_req = 1'b1;
      #1;
      check("R10 immediate permit on late request", int'(tx_permit), 1);
      @(negedge clk);

      // R11: frame end mid-gap restarts count
      frame_end();
      ticks(3, seen);
      frame_end();
      measure(n);
      check("R11 restart mid-gap", n, 5);

      // R6: carrier in early window defers and restarts
      full_duplex = 1'b0; back_to_back = 1'b0;
      gap_win1 = 7'd10; gap_win2 = 7'd20;
      frame_end();
      ticks(4, seen);
      carrier = 1'b1;
      @(negedge clk);
      ticks(8, seen);
      check("R6 no permit while deferring", seen, 0);
      carrier = 1'b0;
      @(negedge clk);
      measure(n);
      check("R6 full gap after carrier drop", n, 26);

      // R7: carrier in late window ignored
      frame_end();
      ticks(12, seen);
      carrier = 1'b1;
      @(negedge clk);
      measure(n);
      check("R7 late carrier ignored", n, 14);
      carrier = 1'b0;

      // R8: full duplex ignores carrier
      full_duplex = 1'b1; gap_b2b = 7'h15;
      carrier = 1'b1;
      frame_end();
      measure(n);
      check("R8 fd carrier ignored", n, 24);
      carrier = 1'b0;

      finish_time();
   end
endmodule